// File: doc/BRIEF.md
# Auto-Reload Timer Bit-Rate Generator

This block produces the timing ticks for a serial port. An 8-bit timer counts up on a prescaled clock tick, once every twelve system clocks by default. When it rolls over it restarts from a programmed reload value. Each rollover goes through a rate scaler. A double-rate control bit picks the scaling. The scaler gives a 16x oversampling tick and a bit tick at one sixteenth of it. A UART receiver and transmitter use these two ticks for the variable-rate frame formats.

Two fixed-rate ticks are also derived from the system clock alone. The shift-register tick fires once per prescaler period. The fixed-rate 9-bit tick fires every 64 clocks, or every 32 clocks when the double-rate bit is set. All ticks are one-clock-wide registered pulses. The run enable parks every counter in its start state.

For a clock `f`, reload `R` and double-rate bit `D`, the bit rate is `f * 2^D / (32 * PRESCALE * (256 - R))`.

Top module: `brg_top`

## Requirements
- R1: After reset, and on every cycle after `run_en` has been sampled low, all four tick outputs are 0.
- R2: With `dbl_rate`=1, `os_tick` fires once per timer rollover. The spacing is `PRESCALE*(256-reload_val)` clocks, which is 36 clocks for reload 0xFD.
- R3: With `dbl_rate`=0, `os_tick` fires on every second rollover. The spacing is `2*PRESCALE*(256-reload_val)` clocks.
- R4: `bit_tick` fires only in a cycle where `os_tick` is also high, on every 16th `os_tick`. Its spacing is therefore 16 oversample periods.
- R5: Every tick output is high for exactly one clock per pulse.
- R6: A new `reload_val` is taken at the next rollover. The count already in progress finishes at the old period.
- R7: `shift_tick` fires every `PRESCALE` clocks (12) while running, independent of `reload_val` and `dbl_rate`.
- R8: `fixed_tick` fires every 64 clocks when `dbl_rate`=0 and every 32 clocks when `dbl_rate`=1.
- R9: Reload 0xFF with `dbl_rate`=1 gives the fastest variable rate. `os_tick` then fires every 12 clocks and `bit_tick` every 192 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; low holds all counters at their start state |
| reload_val | input | TMR_W | Value loaded into the timer on rollover |
| dbl_rate | input | 1 | Double-rate select for the variable and fixed 9-bit rates |
| os_tick | output | 1 | 16x oversampling tick for the variable-rate modes |
| bit_tick | output | 1 | Bit tick for the variable-rate modes |
| shift_tick | output | 1 | Shift-register mode bit tick |
| fixed_tick | output | 1 | Fixed-rate 9-bit mode bit tick |

## Verification
Four properties are checked on every cycle: ticks stay quiet once the enable is low, the ticks are single-cycle, a bit tick always coincides with an oversample tick, and the shift tick spacing holds. Only the bench scenarios can show the rate arithmetic. That covers the rollover period for a given reload value, the halving by the double-rate bit, the 16:1 ratio, and the reload update that waits for the next rollover. The bench measures pulse spacing for directed and random reload values and compares it with the period formula.

// File: rtl/brg_pkg.sv
package brg_pkg;
  // Bundle of the four registered tick outputs.
  typedef struct packed {
    logic os;
    logic bt;
    logic sh;
    logic fx;
  } brg_ticks_t;

  // Clocks between rollovers for a given reload value (reference helper).
  function automatic int unsigned rollover_clks(input int unsigned pre,
                                                input int unsigned span);
    return pre * span;
  endfunction
endpackage

// File: rtl/brg_divider.sv
// Free-running modulo-DIV counter; tick is high in the last count state.
module brg_divider #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = en;
    end else begin : g_count
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || !en) begin
          cnt_q <= '0;
        end else if (cnt_q == LAST) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      assign tick = en && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/brg_reload_timer.sv
// Up-counting timer that reloads itself on rollover; ovf is a registered pulse.
module brg_reload_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             step,
  input  logic [TMR_W-1:0] reload,
  output logic             ovf
);
  logic [TMR_W-1:0] cnt_q;
  logic             ovf_q;
  logic             at_top;

  assign at_top = (cnt_q == {TMR_W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= reload;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= step && at_top;
      if (step) begin
        cnt_q <= at_top ? reload : cnt_q + 1'b1;
      end
    end
  end

  assign ovf = ovf_q;
endmodule

// File: rtl/brg_rate_scaler.sv
// Turns rollover pulses into the oversample tick (every rollover or every
// second one) and the bit tick (every OS_DIV-th oversample tick).
module brg_rate_scaler #(
  parameter int OS_DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ovf,
  input  logic dbl,
  output logic os_tick,
  output logic bit_tick
);
  localparam int BW = (OS_DIV > 1) ? $clog2(OS_DIV) : 1;
  localparam logic [BW-1:0] BLAST = BW'(OS_DIV - 1);

  logic          half_q;
  logic [BW-1:0] bcnt_q;
  logic          os_q, bit_q;
  logic          fire;

  assign fire = ovf && (dbl || half_q);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      half_q <= 1'b0;
      bcnt_q <= '0;
      os_q   <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      if (ovf) half_q <= !half_q;
      os_q  <= fire;
      bit_q <= fire && (bcnt_q == BLAST);
      if (fire) bcnt_q <= (bcnt_q == BLAST) ? '0 : bcnt_q + 1'b1;
    end
  end

  assign os_tick  = os_q;
  assign bit_tick = bit_q;
endmodule

// File: rtl/brg_fixed_rate.sv
// Fixed-rate 9-bit mode tick: BASE clocks when dbl is set, 2*BASE otherwise.
module brg_fixed_rate #(
  parameter int BASE = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic dbl,
  output logic tick
);
  logic base_tick;
  logic half_q, tick_q;

  brg_divider #(.DIV(BASE)) base_div_i (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .tick(base_tick)
  );

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      half_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      if (base_tick) half_q <= !half_q;
      tick_q <= base_tick && (dbl || half_q);
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/brg_top.sv
module brg_top
  import brg_pkg::*;
#(
  parameter int PRESCALE = 12,
  parameter int TMR_W    = 8,
  parameter int OS_DIV   = 16,
  parameter int FIX_BASE = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [TMR_W-1:0] reload_val,
  input  logic             dbl_rate,
  output logic             os_tick,
  output logic             bit_tick,
  output logic             shift_tick,
  output logic             fixed_tick
);
  logic       pre_tick;
  logic       ovf;
  logic       os_w, bit_w, fx_w;
  logic       sh_q;
  brg_ticks_t tk;

  brg_divider #(.DIV(PRESCALE)) pre_i (
    .clk (clk),
    .rst (rst),
    .en  (run_en),
    .tick(pre_tick)
  );

  brg_reload_timer #(.TMR_W(TMR_W)) tmr_i (
    .clk   (clk),
    .rst   (rst),
    .en    (run_en),
    .step  (pre_tick),
    .reload(reload_val),
    .ovf   (ovf)
  );

  brg_rate_scaler #(.OS_DIV(OS_DIV)) scl_i (
    .clk     (clk),
    .rst     (rst),
    .en      (run_en),
    .ovf     (ovf),
    .dbl     (dbl_rate),
    .os_tick (os_w),
    .bit_tick(bit_w)
  );

  brg_fixed_rate #(.BASE(FIX_BASE)) fix_i (
    .clk (clk),
    .rst (rst),
    .en  (run_en),
    .dbl (dbl_rate),
    .tick(fx_w)
  );

  always_ff @(posedge clk) begin
    if (rst || !run_en) sh_q <= 1'b0;
    else                sh_q <= pre_tick;
  end

  assign tk = '{os: os_w, bt: bit_w, sh: sh_q, fx: fx_w};

  assign os_tick    = tk.os;
  assign bit_tick   = tk.bt;
  assign shift_tick = tk.sh;
  assign fixed_tick = tk.fx;
endmodule

// File: rtl/brg_checker.sv
module brg_checker #(
  parameter int PRESCALE = 12
) (
  input logic clk,
  input logic rst,
  input logic run_en,
  input logic os_tick,
  input logic bit_tick,
  input logic shift_tick,
  input logic fixed_tick
);
  logic [15:0] sh_gap_q;
  logic        sh_seen_q;

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      sh_gap_q  <= '0;
      sh_seen_q <= 1'b0;
    end else if (shift_tick) begin
      sh_gap_q  <= '0;
      sh_seen_q <= 1'b1;
    end else begin
      sh_gap_q <= sh_gap_q + 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !(os_tick || bit_tick || shift_tick || fixed_tick)); // R1

  AST_BIT_WITH_OS: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> os_tick); // R4

  AST_OS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    os_tick |=> !os_tick); // R5

  AST_FIXED_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fixed_tick |=> !fixed_tick); // R5

  AST_SHIFT_SPACING: assert property (@(posedge clk) disable iff (rst)
    (shift_tick && sh_seen_q && run_en) |-> (sh_gap_q == 16'(PRESCALE - 1))); // R7
endmodule

bind brg_top brg_checker #(.PRESCALE(PRESCALE)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .run_en    (run_en),
  .os_tick   (os_tick),
  .bit_tick  (bit_tick),
  .shift_tick(shift_tick),
  .fixed_tick(fixed_tick)
);

// File: tb/brg_top_tb_top.sv
module brg_top_tb_top;
  localparam int PRE = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run_en = 1'b0;
  logic [7:0] reload_val = 8'hFD;
  logic       dbl_rate = 1'b0;
  logic       os_tick, bit_tick, shift_tick, fixed_tick;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int os_since_bit = 0;
  bit bit_valid = 1'b0;
  bit prev_os = 1'b0;
  bit width_fail = 1'b0;

  always #4 clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  brg_top dut_i (
    .clk(clk), .rst(rst), .run_en(run_en), .reload_val(reload_val),
    .dbl_rate(dbl_rate), .os_tick(os_tick), .bit_tick(bit_tick),
    .shift_tick(shift_tick), .fixed_tick(fixed_tick)
  );

  function automatic int os_period(input int r, input bit d);
    return PRE * (256 - r) * (d ? 1 : 2);
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // Monitor: 16:1 ratio and coincidence of bit and os ticks (R4), widths (R5)
  always @(negedge clk) begin
    if (rst || !run_en) begin
      os_since_bit <= 0;
      bit_valid    <= 1'b0;
    end else begin
      if (os_tick && prev_os) width_fail <= 1'b1;
      if (bit_tick) begin
        chk("R4 bit_tick with os_tick", int'(os_tick), 1);
        if (bit_valid) chk("R4 os ticks per bit", os_since_bit + 1, 16);
        os_since_bit <= 0;
        bit_valid    <= 1'b1;
      end else if (os_tick) begin
        os_since_bit <= os_since_bit + 1;
      end
    end
    prev_os <= os_tick;
  end

  function automatic bit pick(input int sel);
    case (sel)
      0: return os_tick;
      1: return bit_tick;
      2: return shift_tick;
      default: return fixed_tick;
    endcase
  endfunction

  task automatic wait_pulse(input int sel);
    do @(negedge clk); while (!pick(sel));
  endtask

  task automatic gap_of(input int sel, output int g);
    int t0;
    wait_pulse(sel);
    t0 = cyc;
    wait_pulse(sel);
    g = cyc - t0;
  endtask

  task automatic settled_gap(input int sel, output int g);
    int dummy;
    gap_of(sel, dummy);
    gap_of(sel, g);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int g;
    int t0;
    int quiet;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset os", int'(os_tick), 0);
    chk("R1 reset bit", int'(bit_tick), 0);
    rst = 1'b0;
    quiet = 0;
    repeat (60) begin
      @(negedge clk);
      if (os_tick || bit_tick || shift_tick || fixed_tick) quiet++;
    end
    chk("R1 idle outputs quiet", quiet, 0);

    // R2, R7, R8 at reload 0xFD, double rate
    reload_val = 8'hFD; dbl_rate = 1'b1;
    @(negedge clk); run_en = 1'b1;
    settled_gap(0, g); chk("R2 os period FD dbl", g, os_period(8'hFD, 1'b1));
    settled_gap(1, g); chk("R4 bit period FD dbl", g, 16 * os_period(8'hFD, 1'b1));
    settled_gap(2, g); chk("R7 shift period", g, PRE);
    settled_gap(3, g); chk("R8 fixed period dbl", g, 32);

    // R3, R8 single rate
    dbl_rate = 1'b0;
    settled_gap(0, g); chk("R3 os period FD single", g, os_period(8'hFD, 1'b0));
    settled_gap(3, g); chk("R8 fixed period single", g, 64);
    settled_gap(2, g); chk("R7 shift period single", g, PRE);

    // R9 fastest rate
    reload_val = 8'hFF; dbl_rate = 1'b1;
    settled_gap(0, g); chk("R9 os period FF", g, 12);
    settled_gap(1, g); chk("R9 bit period FF", g, 192);

    // random reload/rate mix
    for (int i = 0; i < 8; i++) begin
      int r;
      bit d;
      r = 8'hF0 + int'($urandom % 16);
      d = 1'($urandom % 2);
      reload_val = 8'(r); dbl_rate = d;
      settled_gap(0, g);
      chk(d ? "R2 random os period" : "R3 random os period", g, os_period(r, d));
    end

    // R6: reload change mid-count
    reload_val = 8'hF8; dbl_rate = 1'b1;
    settled_gap(0, g); chk("R6 pre-change period", g, 96);
    wait_pulse(0);
    t0 = cyc;
    repeat (10) @(negedge clk);
    reload_val = 8'hFE;
    wait_pulse(0);
    chk("R6 count in progress keeps old period", cyc - t0, 96);
    gap_of(0, g);
    chk("R6 new reload after rollover", g, 24);

    // R5 width summary
    chk("R5 os_tick single-cycle", int'(width_fail), 0);

    // R1: enable dropped
    run_en = 1'b0;
    @(negedge clk);
    quiet = 0;
    repeat (200) begin
      @(negedge clk);
      if (os_tick || bit_tick || shift_tick || fixed_tick) quiet++;
    end
    chk("R1 disabled outputs quiet", quiet, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule